// File: doc/BRIEF.md
# Dual Prescaled Timer/Counter Pair

This block holds two 16-bit up-counting timers, channel 0 and channel 1, run from one module clock. A single 16-bit control word gives each channel a run switch, a mode switch and a 3-bit source select. In timer mode a channel advances on a divided module clock. A free-running prescaler shared by both channels supplies a power-of-two rate. A global staggered flag shifts the range of divide ratios up by three octaves. In counter mode a channel counts overflow strobes from an external general-purpose timer, or edges on its own input pin after a two-flop synchronizer.

When a channel sits at 0xFFFF and sees one more count event, it reloads from its reload register and raises its overflow output for one clock. Channel 1 accepts only the external-overflow source in counter mode and halts on any other selection. A register port writes the control word, both counts and both reloads, and reads them back.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After reset the control word, both counts and both reloads read 0x0000 and both overflow outputs are low.
- R2: Register addresses are 0 control, 1 count of channel 0, 2 reload of channel 0, 3 count of channel 1, 4 reload of channel 1. Addresses 5 to 7 read 0. In the control word, channel 1 uses bit 14 for run, bit 11 for mode and bits 10:8 for source select. Channel 0 uses bit 6 for run, bit 3 for mode and bits 2:0 for source select. Every other control bit reads back 0, whatever was written.
- R3: A channel whose run bit is 0 keeps its count unchanged, whatever its mode, source select and inputs are.
- R4: In timer mode (mode bit 0) a channel advances once every 2^k module clocks. k is the source select when the staggered flag is 0, and the source select plus 3 when it is 1. The shared prescaler counts up from 0 after reset. A tick occurs on the clock in which its low k bits are all ones.
- R5: In counter mode (mode bit 1) the source codes are: 000 counts each cycle in which the external overflow strobe is high, 001 rising pin edges, 010 falling pin edges, 011 both edges. A pin passes two synchronizing flops, and its count changes on the third rising clock edge after the pin changes. Each edge adds exactly 1.
- R6: In counter mode, source codes 100 to 111 cause no counting.
- R7: Channel 1 in counter mode counts only with source code 000. With any other code it stays stopped.
- R8: A count event at 0xFFFF loads the reload value that held before that clock. The channel's overflow output is then high for exactly the following clock. No other event raises it.
- R9: A write to a count register sets the count to the written value, even if a count event falls in the same clock, and it raises no overflow.
- R10: Reads return the present count, reload and masked control values combinationally for the given read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stagger_i | input | 1 | Staggered-rate flag, moves the timer-mode divide range up by 2^3 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data |
| pin_i | input | 2 | Asynchronous count pins, bit n feeds channel n |
| ext_ovf_i | input | 1 | Overflow strobe of an external timer, synchronous, one clock per event |
| ovf_o | output | 2 | Per-channel overflow pulse |

## Verification
The assertions assume that the external overflow strobe is synchronous to the module clock and that each high cycle stands for one event. The edge assertion also assumes that the pins are sampled cleanly at the clock edge. The stimulus drives every input, including the pins, only on falling clock edges, so the pins never change near the rising edge. Every high clock of the strobe is treated as one event, both by the bench model and by the block. Register writes are single-cycle strobes, and the comparison against the model covers cycles where writes and count events collide.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  localparam int CNT_W    = 16;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = 3;
  localparam int STAG_OFS = 3;
  localparam int PSC_W    = (1 << SEL_W) - 1 + STAG_OFS;
  localparam int SHIFT_W  = $clog2(PSC_W + 1);
  localparam int N_CH     = 2;
  localparam int FIELD_STRIDE = 8;
  localparam int RUN_POS  = 6;
  localparam int MODE_POS = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD0 = 3'd2;
  localparam logic [DATA_W-1:0] CTRL_MASK = 16'h4F4F;

  typedef struct packed {
    logic             run;
    logic             mode;
    logic [SEL_W-1:0] sel;
  } tmr_cfg_t;

  typedef enum logic [SEL_W-1:0] {
    SRC_EXT  = 3'b000,
    SRC_RISE = 3'b001,
    SRC_FALL = 3'b010,
    SRC_BOTH = 3'b011
  } cnt_src_e;

  function automatic tmr_cfg_t cfg_slice(input logic [DATA_W-1:0] ctrl, input int idx);
    tmr_cfg_t c;
    c.run  = ctrl[idx*FIELD_STRIDE + RUN_POS];
    c.mode = ctrl[idx*FIELD_STRIDE + MODE_POS];
    c.sel  = ctrl[idx*FIELD_STRIDE +: SEL_W];
    return c;
  endfunction

  function automatic logic [SHIFT_W-1:0] rate_shift(input logic [SEL_W-1:0] sel, input logic stag);
    logic [SHIFT_W-1:0] base;
    base = SHIFT_W'(sel);
    return stag ? base + SHIFT_W'(STAG_OFS) : base;
  endfunction
endpackage

// File: rtl/dtp_prescaler.sv
module dtp_prescaler #(
  parameter int PW = dtp_pkg::PSC_W
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [PW:0] tick_o
);
  logic [PW-1:0] psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_q + 1'b1;
  end

  assign tick_o[0] = 1'b1;
  for (genvar k = 1; k <= PW; k++) begin : g_tap
    assign tick_o[k] = &psc_q[k-1:0];
  end
endmodule

// File: rtl/dtp_pin_sync.sv
module dtp_pin_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, stab_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin_i;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign rise_o = stab_q & ~hist_q;
  assign fall_o = ~stab_q & hist_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_RISE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |-> $past(pin_i[i], 2)) else $error("rise without pin high"); // R5
    AST_FALL_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |-> !$past(pin_i[i], 2)) else $error("fall without pin low"); // R5
  end
endmodule

// File: rtl/dtp_channel.sv
module dtp_channel
  import dtp_pkg::*;
#(
  parameter int  W       = CNT_W,
  parameter bit  PIN_SRC = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tmr_cfg_t       cfg_i,
  input  logic           stag_i,
  input  logic [PSC_W:0] tick_i,
  input  logic           rise_i,
  input  logic           fall_i,
  input  logic           ext_ovf_i,
  input  logic           wr_cnt_i,
  input  logic           wr_rld_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   count_o,
  output logic [W-1:0]   reload_o,
  output logic           ovf_o,
  output logic           cnt_ev_o
);
  localparam logic [W-1:0] TOP = '1;

  logic           src_ev, illegal_src;
  logic [W-1:0]   cnt_q, rld_q;
  logic           ovf_q;
  logic           wrap;

  always_comb begin
    src_ev = 1'b0;
    if (!cfg_i.mode) begin
      src_ev = tick_i[rate_shift(cfg_i.sel, stag_i)];
    end else begin
      unique case (cfg_i.sel)
        SRC_EXT:  src_ev = ext_ovf_i;
        SRC_RISE: src_ev = rise_i;
        SRC_FALL: src_ev = fall_i;
        SRC_BOTH: src_ev = rise_i | fall_i;
        default:  src_ev = 1'b0;
      endcase
    end
  end

  assign illegal_src = cfg_i.mode && !PIN_SRC && (cfg_i.sel != SRC_EXT);
  assign cnt_ev_o    = cfg_i.run && src_ev && !illegal_src;
  assign wrap        = cnt_ev_o && !wr_cnt_i && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_rld_i) rld_q <= wdata_i;
      if (wr_cnt_i)      cnt_q <= wdata_i;
      else if (wrap)     cnt_q <= rld_q;
      else if (cnt_ev_o) cnt_q <= cnt_q + 1'b1;
      ovf_q <= wrap;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
  assign ovf_o    = ovf_q;

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.run && !wr_cnt_i) |=> $stable(cnt_q)) else $error("stopped channel moved"); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ev_o && !wr_cnt_i && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1) else $error("step not one"); // R5
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.mode && cfg_i.sel[SEL_W-1] && !wr_cnt_i) |=> $stable(cnt_q)) else $error("reserved code counted"); // R6
  AST_OVF_AFTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> ($past(cnt_q) == TOP && !$past(wr_cnt_i))) else $error("overflow not from top"); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> (cnt_q == $past(wdata_i) && !ovf_o)) else $error("write lost"); // R9

  if (!PIN_SRC) begin : g_ext_only
    AST_HALT_ON_PIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.mode && cfg_i.sel != SRC_EXT && !wr_cnt_i) |=> $stable(cnt_q)) else $error("halted channel moved"); // R7
  end
endmodule

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer
  import dtp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stagger_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_CH-1:0]   pin_i,
  input  logic              ext_ovf_i,
  output logic [N_CH-1:0]   ovf_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [PSC_W:0]    tick;
  logic [N_CH-1:0]   rise, fall, cnt_ev;
  logic [CNT_W-1:0]  count [N_CH];
  logic [CNT_W-1:0]  reload [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL)   ctrl_q <= wr_data_i & CTRL_MASK;
  end

  dtp_prescaler #(.PW(PSC_W)) i_psc (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  dtp_pin_sync #(.N(N_CH)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CNT_A = A_CNT0 + ADDR_W'(2*g);
    localparam logic [ADDR_W-1:0] RLD_A = A_RLD0 + ADDR_W'(2*g);
    dtp_channel #(.W(CNT_W), .PIN_SRC(g == 0)) i_ch (
      .clk(clk), .rst_n(rst_n),
      .cfg_i(cfg_slice(ctrl_q, g)), .stag_i(stagger_i), .tick_i(tick),
      .rise_i(rise[g]), .fall_i(fall[g]), .ext_ovf_i(ext_ovf_i),
      .wr_cnt_i(wr_en_i && wr_addr_i == CNT_A),
      .wr_rld_i(wr_en_i && wr_addr_i == RLD_A),
      .wdata_i(wr_data_i),
      .count_o(count[g]), .reload_o(reload[g]),
      .ovf_o(ovf_o[g]), .cnt_ev_o(cnt_ev[g])
    );
    AST_EVENT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ev[g] |-> ctrl_q[g*FIELD_STRIDE + RUN_POS]) else $error("event while stopped"); // R3
  end

  always_comb begin
    unique case (rd_addr_i)
      3'd0:    rd_data_o = ctrl_q;
      3'd1:    rd_data_o = count[0];
      3'd2:    rd_data_o = reload[0];
      3'd3:    rd_data_o = count[1];
      3'd4:    rd_data_o = reload[1];
      default: rd_data_o = '0;
    endcase
  end

  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_CTRL) |=> (ctrl_q == ($past(wr_data_i) & 16'h4F4F))) else $error("control bits"); // R2
endmodule

// File: tb/test_dual_prescaled_timer.sv
module test_dual_prescaled_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stagger_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic [1:0]  pin_i = '0;
  logic        ext_ovf_i = 1'b0;
  logic [1:0]  ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  dual_prescaled_timer i_dual_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .stagger_i(stagger_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .pin_i(pin_i), .ext_ovf_i(ext_ovf_i), .ovf_o(ovf_o)
  );

  // behavioural reference
  int m_ctrl, m_psc;
  int m_cnt[2], m_rld[2];
  bit m_ovf[2];
  bit m_sa[2], m_sb[2], m_sh[2];

  function automatic int m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt[0];
      2: return m_rld[0];
      3: return m_cnt[1];
      4: return m_rld[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_psc = 0;
      foreach (m_cnt[i]) begin
        m_cnt[i] = 0; m_rld[i] = 0; m_ovf[i] = 0;
        m_sa[i] = 0; m_sb[i] = 0; m_sh[i] = 0;
      end
    end else begin
      int nctrl;
      nctrl = m_ctrl;
      for (int i = 0; i < 2; i++) begin
        int fld, sel, k, ncnt, nrld;
        bit run, md, ev, up, dn;
        fld = (m_ctrl >> (8*i)) & 'hFF;
        run = fld[6]; md = fld[3]; sel = fld & 7;
        up = m_sb[i] && !m_sh[i];
        dn = !m_sb[i] && m_sh[i];
        if (!md) begin
          k = stagger_i ? sel + 3 : sel;
          ev = ((m_psc + 1) % (1 << k)) == 0;
        end else if (i == 1 && sel != 0) ev = 0;
        else if (sel == 0) ev = ext_ovf_i;
        else if (sel == 1) ev = up;
        else if (sel == 2) ev = dn;
        else if (sel == 3) ev = up || dn;
        else ev = 0;
        ev = ev && run;
        ncnt = m_cnt[i]; nrld = m_rld[i]; m_ovf[i] = 0;
        if (wr_en_i && wr_addr_i == 3'(1 + 2*i)) ncnt = wr_data_i;
        else if (ev && m_cnt[i] == 'hFFFF) begin ncnt = m_rld[i]; m_ovf[i] = 1; end
        else if (ev) ncnt = m_cnt[i] + 1;
        if (wr_en_i && wr_addr_i == 3'(2 + 2*i)) nrld = wr_data_i;
        m_cnt[i] = ncnt; m_rld[i] = nrld;
        m_sh[i] = m_sb[i]; m_sb[i] = m_sa[i]; m_sa[i] = pin_i[i];
      end
      if (wr_en_i && wr_addr_i == 3'd0) nctrl = wr_data_i & 'h4F4F;
      m_ctrl = nctrl;
      m_psc = (m_psc + 1) % 1024;
    end
  end

  task automatic check(input string t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", t, got, exp);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({tag, " R10 rd"}, int'(rd_data_o), m_read(int'(rd_addr_i)));
      check({tag, " R8 ovf0"}, int'(ovf_o[0]), int'(m_ovf[0]));
      check({tag, " R8 ovf1"}, int'(ovf_o[1]), int'(m_ovf[1]));
      rd_addr_i <= rd_addr_i + 3'd1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic toggles(input int bit_i, input int n, input int gap);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      pin_i[bit_i] = ~pin_i[bit_i];
      cyc(gap);
    end
  endtask

  task automatic ext_pulses(input int n, input int gap);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); ext_ovf_i = 1'b1;
      @(negedge clk); ext_ovf_i = 1'b0;
      cyc(gap);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    tag = "R1"; cyc(16);
    tag = "R2"; wr(3'd0, 16'hFFFF); cyc(10);
    check("R2 ctrl readback model", m_ctrl, 'h4F4F);
    wr(3'd0, 16'h0000); cyc(8);
    tag = "R4";
    wr(3'd0, 16'h4240); cyc(60);
    stagger_i = 1'b1; wr(3'd0, 16'h4041); cyc(200);
    stagger_i = 1'b0; wr(3'd0, 16'h0047); cyc(300);
    tag = "R3";
    wr(3'd0, 16'h4040); cyc(10);
    wr(3'd0, 16'h0808); toggles(0, 4, 3); ext_pulses(3, 2); cyc(10);
    tag = "R8";
    wr(3'd2, 16'hABCD); wr(3'd1, 16'hFFF8); wr(3'd0, 16'h0040); cyc(20);
    wr(3'd4, 16'h0010); wr(3'd3, 16'hFFFC); wr(3'd0, 16'h4040); cyc(30);
    wr(3'd2, 16'hFFFF); wr(3'd1, 16'hFFFE); cyc(12);
    tag = "R9";
    wr(3'd0, 16'h4040);
    for (int j = 0; j < 6; j++) wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'h1234); cyc(6);
    tag = "R5";
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0049); toggles(0, 6, 3); cyc(6);
    wr(3'd0, 16'h004A); toggles(0, 6, 1); cyc(6);
    wr(3'd0, 16'h004B); toggles(0, 8, 0); cyc(6);
    wr(3'd0, 16'h0048); ext_pulses(5, 1);
    @(negedge clk); ext_ovf_i = 1'b1; cyc(4); ext_ovf_i = 1'b0; cyc(6);
    tag = "R6";
    for (int s = 4; s < 8; s++) begin
      wr(3'd0, 16'(16'h0048 | s));
      toggles(0, 4, 2); ext_pulses(3, 1); cyc(4);
    end
    tag = "R7";
    wr(3'd0, 16'h4800); ext_pulses(6, 1); cyc(4);
    for (int s = 1; s < 8; s++) begin
      wr(3'd0, 16'(16'h4800 | (s << 8)));
      toggles(1, 4, 2); toggles(0, 2, 2); ext_pulses(3, 1); cyc(4);
    end
    tag = "R10";
    for (int j = 0; j < 4000; j++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 99));
      pin_i = 2'($urandom);
      ext_ovf_i = ($urandom_range(0, 3) == 0);
      if (r < 4) begin
        wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 16'($urandom);
      end else if (r < 8) begin
        wr_en_i = 1'b1; wr_addr_i = 3'($urandom_range(1, 7));
        wr_data_i = ($urandom_range(0, 1) == 0) ? 16'hFFF0 | 16'($urandom_range(0, 15)) : 16'($urandom);
      end else begin
        wr_en_i = 1'b0;
      end
      if (r == 99) stagger_i = ~stagger_i;
    end
    @(negedge clk); wr_en_i = 1'b0;
    cyc(10);
    finish_run();
  end
endmodule